// File: doc/BRIEF.md
# Supply voltage monitor controller

This block is the digital control and status logic that sits behind an analog supply comparator. Two comparator indications arrive asynchronously: the supply is below the falling trip level, and the supply is above the rising trip level. After a two-flop synchronizer, the block does three things with them. It keeps a status flag that mirrors the "below" indication. It raises an interrupt flag whenever that status flag changes in either direction. When resets are enabled, it issues a chip reset request. That request stays asserted until the supply climbs back above the rising trip level.

Configuration arrives as plain pins: a monitor power-disable, a reset-disable and a stop-mode enable. A small two-address register port holds the remaining state. Address 0 holds the status/control register, which has the mirrored flag, the interrupt flag, the interrupt enable and a write-one acknowledge bit. Address 1 holds the 2-bit trip-level select, which the block drives out to the analog side. The power-on reset pulse is an input and clears all state. There is no streaming data path, so every pin is a plain control or status level.

Top module: `svm_ctrl`

## Requirements
- R1: While `por_i` is high and right after it falls, the state is as follows: `rst_req_o`=0, `rst_pad_n_o`=1, `irq_o`=0, `trip_code_o`=2'b01 (the 3V code) and the status register reads 0.
- R2: With `cfg_pwr_dis_i`=1 the monitor is off. `rst_req_o` is released on the next edge, and the status and interrupt flags hold their values.
- R3: With the monitor active and `cfg_rst_dis_i`=0, a synchronized "below" indication sets `rst_req_o`. A change on `cmp_below_i` reaches this logic after two synchronizer flops, so the request is registered on the third rising edge after the change.
- R4: Once set, `rst_req_o` stays at 1 until a synchronized "above" indication is seen while the monitor is active. It falls on the third edge after `cmp_above_i` rises.
- R5: `rst_pad_n_o` is low exactly while `rst_req_o` is high.
- R6: Status read data bit 7 follows the synchronized "below" indication, with the same three-edge latency, while the monitor is active.
- R7: Status read data bit 6 (the interrupt flag) sets on every change of bit 7, whether it rises or falls.
- R8: `irq_o` is 1 exactly when the interrupt flag and the interrupt enable (status bit 1, written through `reg_wdata_i[1]`) are both 1 and `rst_req_o` is 0.
- R9: A status write with `reg_wdata_i[0]`=1 clears the interrupt flag. If a set event falls in the same cycle, the set wins. Bit 0 always reads as 0.
- R10: On the edge where `rst_req_o` is set, the interrupt enable is cleared, and this overrides a concurrent write.
- R11: A write to address 1 loads `trip_code_o` from `reg_wdata_i[1:0]`. Every power-on reset returns it to 2'b01.
- R12: With `stop_i`=1 and `cfg_stop_en_i`=0, flag updates and reset setting or release are suspended. With `cfg_stop_en_i`=1 they proceed.
- R13: If "below" is already indicated when `por_i` falls and resets are enabled, `rst_req_o` rises on the third edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset pulse, active high, asynchronous |
| cmp_below_i | input | 1 | Comparator: supply below falling trip (async) |
| cmp_above_i | input | 1 | Comparator: supply above rising trip (async) |
| cfg_pwr_dis_i | input | 1 | 1 turns the monitor off |
| cfg_rst_dis_i | input | 1 | 1 blocks reset requests |
| cfg_stop_en_i | input | 1 | 1 keeps the monitor running in stop mode |
| stop_i | input | 1 | Chip is in stop mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects status/control, 1 selects trip select |
| reg_wdata_i | input | 2 | Write data: status [1]=enable, [0]=ack; trip [1:0]=code |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Chip reset request |
| rst_pad_n_o | output | 1 | Active-low external reset drive |
| trip_code_o | output | 2 | Selected trip level code |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the acknowledge write and a flag-setting edge of the status flag. The bench provokes it by driving the comparator and then timing the acknowledge strobe to land on the third edge, and it judges that the flag stays set. The second pair is reset assertion and an armed interrupt. The bench provokes it by enabling interrupts with a pending flag and then lifting the reset disable, and it judges that the enable drops and the interrupt request is masked on that same edge. A behavioural reference model, compared every cycle, covers all other interleavings.

// File: rtl/svm_pkg.sv
`timescale 1ns/1ps
package svm_pkg;
  localparam int TRIP_W     = 2;
  localparam int RDATA_W    = 8;
  localparam int WDATA_W    = 2;
  localparam int SYNC_STAGES = 2;
  localparam logic [TRIP_W-1:0] TRIP_3V = 2'b01;
  localparam int BIT_FLAG = 7;
  localparam int BIT_IFL  = 6;
  localparam int BIT_IE   = 1;
  localparam int BIT_ACK  = 0;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_TRIP = 1'b1;

  typedef struct packed {
    logic flag;
    logic ifl;
    logic ie;
  } svm_stat_t;
endpackage

// File: rtl/svm_sync.sv
`timescale 1ns/1ps
module svm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or posedge por_i) begin
      if (por_i)      stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/svm_rstgen.sv
`timescale 1ns/1ps
module svm_rstgen (
  input  logic clk,
  input  logic por_i,
  input  logic pwr_dis_i,
  input  logic active_i,
  input  logic rst_dis_i,
  input  logic below_i,
  input  logic above_i,
  output logic rst_q_o,
  output logic rst_set_o
);
  logic rst_q, rst_d, set_c;

  always_comb begin
    rst_d = rst_q;
    set_c = 1'b0;
    if (pwr_dis_i) begin
      rst_d = 1'b0;
    end else if (active_i) begin
      if (rst_q && above_i) begin
        rst_d = 1'b0;
      end else if (!rst_q && !rst_dis_i && below_i) begin
        rst_d = 1'b1;
        set_c = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) rst_q <= 1'b0;
    else       rst_q <= rst_d;
  end

  assign rst_q_o   = rst_q;
  assign rst_set_o = set_c;

  // R4: held until the rising trip is seen
  p_hold_until_rise_r4: assert property (@(posedge clk) disable iff (por_i)
    (rst_q && !above_i && !pwr_dis_i) |=> rst_q);
  // R2: disabled monitor never keeps a reset request
  p_pwr_off_release_r2: assert property (@(posedge clk) disable iff (por_i)
    pwr_dis_i |=> !rst_q);
  // R3: armed and below sets the request
  p_below_sets_r3: assert property (@(posedge clk) disable iff (por_i)
    (active_i && !pwr_dis_i && !rst_dis_i && below_i && !above_i) |=> rst_q);
endmodule

// File: rtl/svm_status.sv
`timescale 1ns/1ps
module svm_status
  import svm_pkg::*;
(
  input  logic      clk,
  input  logic      por_i,
  input  logic      active_i,
  input  logic      below_i,
  input  logic      wr_stat_i,
  input  logic      wr_ie_i,
  input  logic      wr_ack_i,
  input  logic      rst_set_i,
  output svm_stat_t stat_o
);
  svm_stat_t st_q, st_d;
  logic      edge_evt;

  assign edge_evt = active_i && (below_i != st_q.flag);

  always_comb begin
    st_d = st_q;
    if (active_i) st_d.flag = below_i;
    if (edge_evt)                      st_d.ifl = 1'b1;
    else if (wr_stat_i && wr_ack_i)    st_d.ifl = 1'b0;
    if (rst_set_i)                     st_d.ie  = 1'b0;
    else if (wr_stat_i)                st_d.ie  = wr_ie_i;
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) st_q <= '0;
    else       st_q <= st_d;
  end

  assign stat_o = st_q;

  // R7: any change of the mirrored flag raises the interrupt flag
  p_edge_sets_flag_r7: assert property (@(posedge clk) disable iff (por_i)
    (active_i && (below_i != st_q.flag)) |=> st_q.ifl);
  // R9: acknowledge without a competing event clears the flag
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (por_i)
    (wr_stat_i && wr_ack_i && !(active_i && (below_i != st_q.flag))) |=> !st_q.ifl);
  // R12: suspended monitor freezes the mirrored flag
  p_stop_freeze_r12: assert property (@(posedge clk) disable iff (por_i)
    !active_i |=> $stable(st_q.flag));
endmodule

// File: rtl/svm_ctrl.sv
`timescale 1ns/1ps
module svm_ctrl
  import svm_pkg::*;
(
  input  logic               clk,
  input  logic               por_i,
  input  logic               cmp_below_i,
  input  logic               cmp_above_i,
  input  logic               cfg_pwr_dis_i,
  input  logic               cfg_rst_dis_i,
  input  logic               cfg_stop_en_i,
  input  logic               stop_i,
  input  logic               reg_wr_i,
  input  logic               reg_addr_i,
  input  logic [WDATA_W-1:0] reg_wdata_i,
  output logic [RDATA_W-1:0] reg_rdata_o,
  output logic               irq_o,
  output logic               rst_req_o,
  output logic               rst_pad_n_o,
  output logic [TRIP_W-1:0]  trip_code_o
);
  logic [1:0]        cmp_s;
  logic              below_s, above_s, active, rst_q, rst_set;
  logic              wr_stat, wr_trip;
  svm_stat_t         stat;
  logic [TRIP_W-1:0] trip_q;

  svm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_i(por_i),
    .d_i({cmp_above_i, cmp_below_i}), .q_o(cmp_s)
  );
  assign below_s = cmp_s[0];
  assign above_s = cmp_s[1];

  assign active  = !cfg_pwr_dis_i && (!stop_i || cfg_stop_en_i);
  assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_STAT);
  assign wr_trip = reg_wr_i && (reg_addr_i == ADDR_TRIP);

  svm_rstgen u_rst (
    .clk(clk), .por_i(por_i), .pwr_dis_i(cfg_pwr_dis_i), .active_i(active),
    .rst_dis_i(cfg_rst_dis_i), .below_i(below_s), .above_i(above_s),
    .rst_q_o(rst_q), .rst_set_o(rst_set)
  );

  svm_status u_stat (
    .clk(clk), .por_i(por_i), .active_i(active), .below_i(below_s),
    .wr_stat_i(wr_stat), .wr_ie_i(reg_wdata_i[BIT_IE]),
    .wr_ack_i(reg_wdata_i[BIT_ACK]), .rst_set_i(rst_set), .stat_o(stat)
  );

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)        trip_q <= TRIP_3V;
    else if (wr_trip) trip_q <= reg_wdata_i[TRIP_W-1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_STAT) begin
      reg_rdata_o[BIT_FLAG] = stat.flag;
      reg_rdata_o[BIT_IFL]  = stat.ifl;
      reg_rdata_o[BIT_IE]   = stat.ie;
    end else begin
      reg_rdata_o[TRIP_W-1:0] = trip_q;
    end
  end

  assign irq_o       = stat.ifl && stat.ie && !rst_q;
  assign rst_req_o   = rst_q;
  assign rst_pad_n_o = !rst_q;
  assign trip_code_o = trip_q;

  // R10: the enable is gone on the edge the reset request appears
  p_rst_clears_ie_r10: assert property (@(posedge clk) disable iff (por_i)
    $rose(rst_q) |-> !stat.ie);
  // R11: trip write lands on the next edge
  p_trip_load_r11: assert property (@(posedge clk) disable iff (por_i)
    wr_trip |=> (trip_q == $past(reg_wdata_i)));
endmodule

// File: tb/svm_ctrl_test.sv
`timescale 1ns/1ps
module svm_ctrl_test;
  logic clk = 0, por = 1;
  logic below = 0, above = 0, pwr_dis = 0, rst_dis = 0, stop_en = 0, stop = 0;
  logic wr = 0, addr = 0;
  logic [1:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, rst_req, pad_n;
  logic [1:0] trip;
  int errors = 0, checks = 0;
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  svm_ctrl uut (
    .clk(clk), .por_i(por), .cmp_below_i(below), .cmp_above_i(above),
    .cfg_pwr_dis_i(pwr_dis), .cfg_rst_dis_i(rst_dis), .cfg_stop_en_i(stop_en),
    .stop_i(stop), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req),
    .rst_pad_n_o(pad_n), .trip_code_o(trip)
  );

  // behavioural reference: comparator history kept in queues
  bit bq[$], aq[$];
  bit m_flag, m_ifl, m_ie, m_rst;
  bit [1:0] m_trip;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or posedge por) begin
    if (por) begin
      bq = '{0, 0}; aq = '{0, 0};
      m_flag = 0; m_ifl = 0; m_ie = 0; m_rst = 0; m_trip = 2'b01;
    end else begin
      bit act, b_s, a_s, n_rst, setev, evt;
      b_s = bq[0]; a_s = aq[0];
      act = !pwr_dis && (!stop || stop_en);
      n_rst = m_rst;
      if (pwr_dis) n_rst = 0;
      else if (act) begin
        if (m_rst && a_s) n_rst = 0;
        else if (!m_rst && !rst_dis && b_s) n_rst = 1;
      end
      setev = n_rst && !m_rst;
      evt = act && (b_s != m_flag);
      if (evt) m_ifl = 1;
      else if (wr && addr == 0 && wdata[0]) m_ifl = 0;
      if (setev) m_ie = 0;
      else if (wr && addr == 0) m_ie = wdata[1];
      if (act) m_flag = b_s;
      if (wr && addr == 1) m_trip = wdata;
      m_rst = n_rst;
      void'(bq.pop_front()); bq.push_back(below);
      void'(aq.pop_front()); aq.push_back(above);
    end
  end

  always @(posedge clk) begin
    #1;
    if (started && !por) begin
      logic [7:0] exp_rd;
      exp_rd = (addr == 0) ? {m_flag, m_ifl, 4'b0, m_ie, 1'b0} : {6'b0, m_trip};
      chk(irq === (m_ifl && m_ie && !m_rst), "R8 irq", irq, m_ifl && m_ie && !m_rst);
      chk(rst_req === m_rst, "R3 rst_req", rst_req, m_rst);
      chk(pad_n === !m_rst, "R5 pad", pad_n, !m_rst);
      chk(trip === m_trip, "R11 trip", trip, m_trip);
      chk(rdata === exp_rd, "R6 rdata", rdata, exp_rd);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wreg(input bit a, input bit [1:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = 0; wdata = 0;
  endtask

  initial begin
    #50000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk(rst_req === 0 && pad_n === 1 && trip === 2'b01 && rdata === 0 && irq === 0,
        "R1 during por", {rst_req, pad_n, trip, irq}, 5'b01010);
    por = 0; started = 1;
    cyc(1);
    chk(rst_req === 0 && trip === 2'b01 && rdata === 0, "R1 after por", rdata, 0);
    // polled mode, interrupts on
    rst_dis = 1;
    wreg(0, 2'b10);
    below = 1; cyc(4);
    chk(rdata[7] === 1, "R6 flag follows below", rdata[7], 1);
    chk(rdata[6] === 1 && irq === 1, "R7 rise sets flag", {rdata[6], irq}, 3);
    chk(rst_req === 0, "R3 disabled reset", rst_req, 0);
    wreg(0, 2'b11); cyc(1);
    chk(rdata[6] === 0 && rdata[0] === 0, "R9 ack clears", rdata, 8'h82);
    below = 0; cyc(4);
    chk(rdata[6] === 1 && rdata[7] === 0, "R7 fall sets flag", rdata, 8'h42);
    wreg(0, 2'b11);
    // ack lands on the same edge as a set event
    @(negedge clk); below = 1;
    cyc(2); wr = 1; addr = 0; wdata = 2'b11;
    @(negedge clk); wr = 0; wdata = 0;
    chk(rdata[6] === 1, "R9 set wins over ack", rdata[6], 1);
    // arm resets while an interrupt is pending
    chk(irq === 1, "R8 irq armed", irq, 1);
    @(negedge clk); rst_dis = 0;
    @(negedge clk);
    chk(rst_req === 1 && pad_n === 0, "R3 reset set", {rst_req, pad_n}, 2);
    chk(rdata[1] === 0 && irq === 0, "R10 ie cleared", {rdata[1], irq}, 0);
    // hysteresis
    below = 0; cyc(8);
    chk(rst_req === 1, "R4 hold without rise", rst_req, 1);
    above = 1; cyc(2);
    chk(rst_req === 1, "R4 still held two edges", rst_req, 1);
    cyc(1);
    chk(rst_req === 0, "R4 released on third edge", rst_req, 0);
    above = 0; cyc(2);
    // stop mode gating
    stop = 1; stop_en = 0; below = 1; cyc(6);
    chk(rdata[7] === 0 && rst_req === 0, "R12 suspended", {rdata[7], rst_req}, 0);
    stop_en = 1; cyc(2);
    chk(rdata[7] === 1 && rst_req === 1, "R12 enabled in stop", {rdata[7], rst_req}, 3);
    stop = 0; stop_en = 0; below = 0; above = 1; cyc(4); above = 0; cyc(2);
    chk(rst_req === 0, "R4 release", rst_req, 0);
    // power disable
    @(negedge clk); pwr_dis = 1; below = 1; cyc(6);
    chk(rst_req === 0 && rdata[7] === 0, "R2 monitor off", {rst_req, rdata[7]}, 0);
    pwr_dis = 0; cyc(2);
    chk(rst_req === 1, "R2 resumes", rst_req, 1);
    @(negedge clk); pwr_dis = 1; cyc(1);
    chk(rst_req === 0, "R2 releases request", rst_req, 0);
    pwr_dis = 0; below = 0; above = 1; cyc(4); above = 0;
    // trip select and power-on with supply already low
    wreg(1, 2'b10); cyc(1);
    chk(trip === 2'b10, "R11 trip written", trip, 2);
    @(negedge clk); por = 1; below = 1; cyc(2);
    chk(trip === 2'b01, "R11 trip back to 3V", trip, 1);
    por = 0; cyc(2);
    chk(rst_req === 0, "R13 not before third edge", rst_req, 0);
    cyc(1);
    chk(rst_req === 1 && pad_n === 0, "R13 immediate reset", rst_req, 1);
    cyc(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule